// File: doc/BRIEF.md
# Triangular Time Base with Fine-Edge Word Encoder

This block turns compare values into parallel bit words for a center-aligned, high-resolution complementary PWM. A shared up/down counter runs once per divided-clock cycle and forms a triangular carrier. Each counter step spans eight fine time slots. Every cycle, each output pair receives one 8-bit word for its positive leg and one for its negative leg. Bit 0 of a word is the earliest fine slot of that cycle, and bit 7 is the latest. A downstream 8:1 serializer, which is outside this block, turns the words into pins with a resolution of one eighth of the divided-clock period.

Per pair, four compare values come from an upstream calculator. Two set the edges while the counter rises: the plain value and the value delayed by dead time. The other two set the edges while the counter falls: the plain value and the value advanced by dead time. In each value, the bits above bit 2 select the coarse counter step and the low three bits select the fine slot. In the first cycle of every carrier period the block takes all compare values from its inputs and holds them for the rest of that period. Both words and the direction flag are registered once before they leave the block.

Top module: `tri_edge_encoder`

## Requirements
- R1: While `rst_n` is low, every word output and `dir_down_o` read 0. The first cycle after reset is counter value 0 in the rising direction.
- R2: With H = PERIOD/16, the counter visits 0, 1, … H−1 while rising and then H, H−1, … 1 while falling. It repeats this with a period of PERIOD/8 cycles and is never 0 while falling.
- R3: `dir_down_o` is 1 exactly for the words produced from a falling-half counter value. It is registered alongside the words, so it is 0 for the H words of the rising half and 1 for the next H.
- R4: While rising, bit i of a positive word is 1 exactly when counter·8 + i ≥ the rising dead-time value. This equals 0x00 below the coarse match, 0xFF shifted left by the low three bits at the match, and 0xFF above it.
- R5: While falling, bit i of a positive word is 1 exactly when counter·8 + i ≥ the plain falling value.
- R6: While rising, bit i of a negative word is 1 exactly when counter·8 + i < the plain rising value. At the coarse match the word is the bitwise inverse of 0xFF shifted left by the low three bits.
- R7: While falling, bit i of a negative word is 1 exactly when counter·8 + i < the falling dead-time value.
- R8: Compare inputs are taken only in the period's first cycle (counter 0, rising). A change at any other cycle has no effect on the words until the next period starts.
- R9: The word for a counter value appears on the outputs after the clock edge that leaves that counter value, which is one register stage.
- R10: Pair k uses bits [k·CW +: CW] of each compare bus and drives bits [k·8 +: 8] of each word bus. The pairs do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock, one counter step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_up_i | input | NPAIR*CW | Plain rising-half compare values, one per pair |
| cmp_up_dt_i | input | NPAIR*CW | Rising-half compare values delayed by dead time |
| cmp_dn_i | input | NPAIR*CW | Plain falling-half compare values |
| cmp_dn_dt_i | input | NPAIR*CW | Falling-half compare values advanced by dead time |
| word_p_o | output | NPAIR*8 | Positive-leg words, bit 0 earliest |
| word_n_o | output | NPAIR*8 | Negative-leg words, bit 0 earliest |
| dir_down_o | output | 1 | 1 when the current words belong to the falling half |

## Verification
The bench builds the block with PERIOD = 64, CW = 7 and NPAIR = 2. These values give a four-step half period and an eight-cycle carrier, so dozens of full periods and every rising/falling turnaround fit into a short run. With a 7-bit compare, coarse values run well past the counter's peak. Every case is therefore exercised: below the match, above the match, and at the match for each fine offset 0 to 7. Two pairs receive different and independently changing values, and the bench changes inputs in mid-period to exercise the sampling rule.

// File: rtl/tri_enc_pkg.sv
package tri_enc_pkg;
   localparam int FINE_BITS = 3;
   localparam int WORD_W    = 1 << FINE_BITS;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;

   // rising = 1: leg turns on at the edge; rising = 0: leg turns off at it
   function automatic logic [WORD_W-1:0] edge_word(input logic below,
                                                   input logic equal,
                                                   input logic [FINE_BITS-1:0] fine,
                                                   input logic rising);
      logic [WORD_W-1:0] ones_from;
      logic [WORD_W-1:0] w;
      ones_from = {WORD_W{1'b1}} << fine;
      if (below)      w = '0;
      else if (equal) w = ones_from;
      else            w = '1;
      return rising ? w : ~w;
   endfunction
endpackage

// File: rtl/tri_counter.sv
module tri_counter
   import tri_enc_pkg::*;
#(
   parameter int PERIOD = 16000,
   parameter int CNT_W  = $clog2(PERIOD/16 + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt,
   output dir_e             dir,
   output logic             start
);
   localparam int HALF = PERIOD / 16;
   localparam logic [CNT_W-1:0] TOP_UP  = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] TOP_DN  = CNT_W'(HALF);
   localparam logic [CNT_W-1:0] LAST_DN = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         dir <= DIR_UP;
      end else if (dir == DIR_UP) begin
         if (cnt == TOP_UP) begin
            cnt <= TOP_DN;
            dir <= DIR_DOWN;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt == LAST_DN) begin
            cnt <= '0;
            dir <= DIR_UP;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign start = (dir == DIR_UP) && (cnt == '0);
endmodule

// File: rtl/tri_cmp_hold.sv
module tri_cmp_hold #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] live,
   output logic [W-1:0] eff
);
   logic [W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held <= '0;
      else if (start) held <= live;
   end

   // first cycle of a period uses the inputs directly, the rest use the copy
   assign eff = start ? live : held;
endmodule

// File: rtl/tri_pair_encoder.sv
module tri_pair_encoder
   import tri_enc_pkg::*;
#(
   parameter int CW    = 16,
   parameter int CNT_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt,
   input  dir_e              dir,
   input  logic [CW-1:0]     c_up,
   input  logic [CW-1:0]     c_up_dt,
   input  logic [CW-1:0]     c_dn,
   input  logic [CW-1:0]     c_dn_dt,
   output logic [WORD_W-1:0] word_p,
   output logic [WORD_W-1:0] word_n
);
   localparam int HI_W  = CW - FINE_BITS;
   localparam int CMP_W = (HI_W > CNT_W) ? HI_W : CNT_W;

   logic [CW-1:0]     sel_p, sel_n;
   logic [CMP_W-1:0]  hi_p, hi_n, cnt_x;
   logic [WORD_W-1:0] nxt_p, nxt_n;

   always_comb begin
      sel_p = (dir == DIR_DOWN) ? c_dn    : c_up_dt;
      sel_n = (dir == DIR_DOWN) ? c_dn_dt : c_up;
      hi_p  = CMP_W'(sel_p[CW-1:FINE_BITS]);
      hi_n  = CMP_W'(sel_n[CW-1:FINE_BITS]);
      cnt_x = CMP_W'(cnt);
      nxt_p = edge_word(cnt_x < hi_p, cnt_x == hi_p, sel_p[FINE_BITS-1:0], 1'b1);
      nxt_n = edge_word(cnt_x < hi_n, cnt_x == hi_n, sel_n[FINE_BITS-1:0], 1'b0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_p <= '0;
         word_n <= '0;
      end else begin
         word_p <= nxt_p;
         word_n <= nxt_n;
      end
   end
endmodule

// File: rtl/tri_edge_encoder.sv
module tri_edge_encoder
   import tri_enc_pkg::*;
#(
   parameter int PERIOD = 16000,
   parameter int NPAIR  = 3,
   parameter int CW     = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPAIR*CW-1:0]     cmp_up_i,
   input  logic [NPAIR*CW-1:0]     cmp_up_dt_i,
   input  logic [NPAIR*CW-1:0]     cmp_dn_i,
   input  logic [NPAIR*CW-1:0]     cmp_dn_dt_i,
   output logic [NPAIR*WORD_W-1:0] word_p_o,
   output logic [NPAIR*WORD_W-1:0] word_n_o,
   output logic                    dir_down_o
);
   localparam int HALF  = PERIOD / 16;
   localparam int CNT_W = $clog2(HALF + 1);
   localparam int SET_W = 4 * CW;

   if (PERIOD % 16 != 0) begin : g_bad_period
      $error("PERIOD must be a multiple of 16");
   end
   if (PERIOD < 32) begin : g_short_period
      $error("PERIOD must be at least 32");
   end
   if (NPAIR < 1) begin : g_bad_npair
      $error("NPAIR must be at least 1");
   end
   if (CW <= FINE_BITS || (1 << (CW - FINE_BITS)) <= HALF) begin : g_narrow_cmp
      $error("CW too narrow to reach the counter peak");
   end

   logic [CNT_W-1:0]       cnt_q;
   dir_e                   cnt_dir;
   logic                   period_start;
   logic [NPAIR*SET_W-1:0] eff_all;

   tri_counter #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt_q),
      .dir   (cnt_dir),
      .start (period_start)
   );

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      logic [SET_W-1:0] live_set;
      logic [SET_W-1:0] eff_set;

      assign live_set = {cmp_dn_dt_i[k*CW +: CW], cmp_dn_i[k*CW +: CW],
                         cmp_up_dt_i[k*CW +: CW], cmp_up_i[k*CW +: CW]};

      tri_cmp_hold #(.W(SET_W)) u_hold (
         .clk   (clk),
         .rst_n (rst_n),
         .start (period_start),
         .live  (live_set),
         .eff   (eff_set)
      );

      assign eff_all[k*SET_W +: SET_W] = eff_set;

      tri_pair_encoder #(.CW(CW), .CNT_W(CNT_W)) u_enc (
         .clk     (clk),
         .rst_n   (rst_n),
         .cnt     (cnt_q),
         .dir     (cnt_dir),
         .c_up    (eff_set[0*CW +: CW]),
         .c_up_dt (eff_set[1*CW +: CW]),
         .c_dn    (eff_set[2*CW +: CW]),
         .c_dn_dt (eff_set[3*CW +: CW]),
         .word_p  (word_p_o[k*WORD_W +: WORD_W]),
         .word_n  (word_n_o[k*WORD_W +: WORD_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_down_o <= 1'b0;
      else        dir_down_o <= (cnt_dir == DIR_DOWN);
   end
endmodule

// File: rtl/tri_enc_chk.sv
module tri_enc_chk #(
   parameter int PERIOD = 16000,
   parameter int NPAIR  = 3,
   parameter int CW     = 16,
   parameter int CNT_W  = 11
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [CNT_W-1:0]       cnt,
   input logic                   dir_down,
   input logic                   start,
   input logic [NPAIR*4*CW-1:0]  eff_all,
   input logic [NPAIR*8-1:0]     word_p_o,
   input logic [NPAIR*8-1:0]     word_n_o
);
   localparam int HALF = PERIOD / 16;

   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(HALF));

   assert_no_zero_falling_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dir_down |-> cnt != '0);

   assert_turn_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_down && cnt == CNT_W'(HALF - 1)) |=> (dir_down && cnt == CNT_W'(HALF)));

   assert_turn_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_down && cnt == CNT_W'(1)) |=> (!dir_down && cnt == '0));

   assert_rise_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_down && cnt != CNT_W'(HALF - 1)) |=> (!dir_down && cnt == $past(cnt) + 1'b1));

   assert_hold_mid_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !start |-> $stable(eff_all));

   for (genvar k = 0; k < NPAIR; k++) begin : g_shape
      // positive words are 0xFF shifted left (or 0x00); negative ones 2^n - 1
      assert_p_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ((~word_p_o[k*8 +: 8]) & ((~word_p_o[k*8 +: 8]) + 8'd1)) == 8'd0);
      assert_n_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (word_n_o[k*8 +: 8] & (word_n_o[k*8 +: 8] + 8'd1)) == 8'd0);
   end
endmodule

bind tri_edge_encoder tri_enc_chk #(
   .PERIOD (PERIOD),
   .NPAIR  (NPAIR),
   .CW     (CW),
   .CNT_W  (CNT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt      (cnt_q),
   .dir_down (cnt_dir == tri_enc_pkg::DIR_DOWN),
   .start    (period_start),
   .eff_all  (eff_all),
   .word_p_o (word_p_o),
   .word_n_o (word_n_o)
);

// File: tb/tri_edge_encoder_tb.sv
`timescale 1ns/1ps
module tri_edge_encoder_tb;
   localparam int PERIOD = 64;
   localparam int NPAIR  = 2;
   localparam int CW     = 7;
   localparam int HALF   = PERIOD / 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                rst_n;
   logic [NPAIR*CW-1:0] up_i, updt_i, dn_i, dndt_i;
   logic [NPAIR*8-1:0]  wp_o, wn_o;
   logic                dir_o;

   tri_edge_encoder #(.PERIOD(PERIOD), .NPAIR(NPAIR), .CW(CW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmp_up_i    (up_i),
      .cmp_up_dt_i (updt_i),
      .cmp_dn_i    (dn_i),
      .cmp_dn_dt_i (dndt_i),
      .word_p_o    (wp_o),
      .word_n_o    (wn_o),
      .dir_down_o  (dir_o)
   );

   typedef struct {
      logic [NPAIR*8-1:0] p;
      logic [NPAIR*8-1:0] n;
      bit                 down;
      bit                 mixed;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   int   m_cnt  = 0;
   bit   m_down = 1'b0;
   logic [NPAIR*CW-1:0] h_up, h_updt, h_dn, h_dndt;

   function automatic logic [7:0] ref_word(int cnt, int c, bit on_after);
      logic [7:0] w;
      for (int i = 0; i < 8; i++) begin
         w[i] = on_after ? ((cnt * 8 + i) >= c) : ((cnt * 8 + i) < c);
      end
      return w;
   endfunction

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // driver side of the scoreboard: predict the word for this edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt  = 0;
         m_down = 1'b0;
      end else begin
         exp_t e;
         bit   start;
         start = (m_cnt == 0) && !m_down;
         if (start) begin
            h_up = up_i; h_updt = updt_i; h_dn = dn_i; h_dndt = dndt_i;
         end
         e.mixed = !start && (up_i != h_up || updt_i != h_updt ||
                              dn_i != h_dn || dndt_i != h_dndt);
         for (int k = 0; k < NPAIR; k++) begin
            int cp, cn;
            cp = m_down ? int'(h_dn[k*CW +: CW])   : int'(h_updt[k*CW +: CW]);
            cn = m_down ? int'(h_dndt[k*CW +: CW]) : int'(h_up[k*CW +: CW]);
            e.p[k*8 +: 8] = ref_word(m_cnt, cp, 1'b1);
            e.n[k*8 +: 8] = ref_word(m_cnt, cn, 1'b0);
         end
         e.down = m_down;
         q.push_back(e);
         if (!m_down) begin
            if (m_cnt == HALF - 1) begin m_cnt = HALF; m_down = 1'b1; end
            else m_cnt++;
         end else begin
            if (m_cnt == 1) begin m_cnt = 0; m_down = 1'b0; end
            else m_cnt--;
         end
      end
   end

   // monitor side: compare away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         chk(wp_o == '0 && wn_o == '0 && dir_o == 1'b0, "R1 reset outputs",
             {wp_o, wn_o, 15'd0, dir_o}, 32'd0);
      end else if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(dir_o == e.down, "R2/R3 direction flag", 32'(dir_o), 32'(e.down));
         for (int k = 0; k < NPAIR; k++) begin
            string tp, tn;
            tp = e.down ? "R5 pos falling" : "R4 pos rising";
            tn = e.down ? "R7 neg falling" : "R6 neg rising";
            if (k == 1) begin tp = {tp, " R10"}; tn = {tn, " R10"}; end
            if (e.mixed) begin tp = {tp, " R8"}; tn = {tn, " R8"}; end
            tp = {tp, " R9"};
            chk(wp_o[k*8 +: 8] == e.p[k*8 +: 8], tp, 32'(wp_o[k*8 +: 8]), 32'(e.p[k*8 +: 8]));
            chk(wn_o[k*8 +: 8] == e.n[k*8 +: 8], tn, 32'(wn_o[k*8 +: 8]), 32'(e.n[k*8 +: 8]));
         end
      end
   end

   task automatic set_pair(int k, int a, int b, int c, int d);
      up_i[k*CW +: CW]   = CW'(a);
      updt_i[k*CW +: CW] = CW'(b);
      dn_i[k*CW +: CW]   = CW'(c);
      dndt_i[k*CW +: CW] = CW'(d);
   endtask

   task automatic wait_cycles(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   initial begin
      rst_n = 1'b0;
      up_i = '0; updt_i = '0; dn_i = '0; dndt_i = '0;
      set_pair(0, 13, 18, 21, 16);   // R4..R7 fine offsets 5,2,5,0
      set_pair(1, 7, 8, 39, 34);     // R10 distinct values on pair 1
      wait_cycles(3);
      rst_n = 1'b1;
      wait_cycles(PERIOD / 8 * 2);
      // R8: mid-period change must wait for the next period
      wait_cycles(3);
      set_pair(0, 0, 0, 40, 40);
      set_pair(1, 31, 39, 8, 15);
      wait_cycles(PERIOD / 8 * 2);
      // coarse values above the peak, fine offset 7
      set_pair(0, 127, 127, 127, 127);
      set_pair(1, 23, 31, 47, 40);
      wait_cycles(PERIOD / 8 * 2);
      // R1: reset in mid-run clears outputs and restarts the carrier
      wait_cycles(2);
      rst_n = 1'b0;
      wait_cycles(3);
      rst_n = 1'b1;
      for (int n = 0; n < 400; n++) begin
         wait_cycles(1);
         if ($urandom_range(0, 2) == 0) begin
            int k;
            k = $urandom_range(0, NPAIR - 1);
            set_pair(k, $urandom_range(0, 127), $urandom_range(0, 127),
                     $urandom_range(0, 127), $urandom_range(0, 127));
         end
      end
      wait_cycles(4);
      summary();
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end
endmodule